// File: doc/BRIEF.md
# Banked Debug State Sequencer

This block steps a debug trigger sequence through three working states. The sequence starts when the arm input rises and ends in a final state. Each working state owns a small control register. That register says which match-channel hits may move the sequencer on, and which state comes next. Reaching the final state produces a single-cycle pulse, and the sequencer then falls back to idle. Comparator logic and tag handling sit outside this block. The block only sees one hit bit per match channel: channel 0 and channel 1.

Software reaches all four registers through one bus address. A 2-bit bank select, held in some other control register, picks the one that is visible at that address:

- The three state control registers.
- A read-only match flag register, which records the hits behind the most recent transition.

Writes to the control registers are refused while the sequencer is armed. A refused write changes nothing.

Top module: `dbg_seq_bank`

## Requirements
- R1: After reset `seq_state` is 0 (idle), `final_pulse` is 0, all three control registers are 0 and the match flag register is 0.
- R2: When `bus_addr` equals `SEQ_ADDR`, `bus_rdata` shows a register chosen by `bank_sel`. Values 0, 1 and 2 show the control register of state 1, 2 and 3 in bits 3:0, with bits 7:4 read as 0. Value 3 shows the match flags in bits 1:0, with bits 7:2 read as 0. Any other address reads 0.
- R3: A write with `bus_we` high, `bus_addr` equal to `SEQ_ADDR` and `bank_sel` 0 to 2 loads `bus_wdata[3:0]` into the selected control register at the clock edge, but only when `armed` is low. Writes while armed, writes with `bank_sel` equal to 3 and writes to other addresses change no register.
- R4: A clock edge at which `armed` is high and was low at the previous edge puts `seq_state` at 1 and clears the match flags.
- R5: Control field encoding, for the register of the current state:
  - Bits 3:2 give the condition: 00 never, 01 channel 0 hit, 10 channel 1 hit, 11 either hit.
  - Bits 1:0 give the target: 00 final, 01 state 1, 10 state 2, 11 state 3.
  - A field of 0000 therefore allows no transition.
- R6: While armed and in state 1 to 3, a clock edge at which the current state's condition holds moves `seq_state` to the target. Otherwise the state is held.
- R7: A transition whose target is final raises `final_pulse` for exactly one cycle, with `seq_state` 0 in that cycle. The sequencer then stays idle while `armed` remains high.
- R8: On every transition the match flag register captures `hit[1:0]` as sampled at that edge. Bit 0 is channel 0 and bit 1 is channel 1.
- R9: A clock edge with `armed` low returns `seq_state` to 0 without a final pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | AW | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| bank_sel | input | 2 | Selects which register is visible at the shared address |
| armed | input | 1 | Debug logic armed |
| hit | input | 2 | Match-channel hits, bit 0 is channel 0 |
| seq_state | output | 2 | 0 idle, 1 to 3 working state |
| final_pulse | output | 1 | One-cycle final-state indication |

## Verification
The bench builds the block with `AW` = 6 and `SEQ_ADDR` = 6'h2A. These values are not the defaults. This checks that the address decode follows the parameters, and not a fixed constant. The random traffic also sends writes to neighbouring addresses, so the decode has to tell the shared address apart from its neighbours. With a narrow address, the random traffic hits the shared address often enough to write every bank, in both the armed and the disarmed case.

// File: rtl/dbg_seq_bank.sv
module dbg_seq_bank #(
  parameter int AW = 8,
  parameter logic [AW-1:0] SEQ_ADDR = 'h14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic [1:0]    bank_sel,
  input  logic          armed,
  input  logic [1:0]    hit,
  output logic [1:0]    seq_state,
  output logic          final_pulse
);

  logic [3:0] ctl_q [3];
  logic [1:0] st_q;
  logic [1:0] flag_q;
  logic       armed_q;
  logic       fin_q;
  logic [3:0] cur_ctl;
  logic       fire;

  wire sel    = (bus_addr == SEQ_ADDR);
  wire wr_ok  = bus_we && sel && (bank_sel != 2'b11) && !armed;
  wire step   = armed && armed_q && (st_q != 2'd0) && fire;
  wire unused_hi = &{1'b0, bus_wdata[7:4]};

  always_comb begin
    case (st_q)
      2'd1:    cur_ctl = ctl_q[0];
      2'd2:    cur_ctl = ctl_q[1];
      2'd3:    cur_ctl = ctl_q[2];
      default: cur_ctl = 4'h0;
    endcase
  end

  always_comb begin
    case (cur_ctl[3:2])
      2'b01:   fire = hit[0];
      2'b10:   fire = hit[1];
      2'b11:   fire = |hit;
      default: fire = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q[0] <= '0;
      ctl_q[1] <= '0;
      ctl_q[2] <= '0;
      st_q     <= '0;
      flag_q   <= '0;
      armed_q  <= 1'b0;
      fin_q    <= 1'b0;
    end else begin
      armed_q <= armed;
      fin_q   <= 1'b0;
      if (wr_ok) begin
        case (bank_sel)
          2'd0:    ctl_q[0] <= bus_wdata[3:0];
          2'd1:    ctl_q[1] <= bus_wdata[3:0];
          default: ctl_q[2] <= bus_wdata[3:0];
        endcase
      end
      if (!armed) begin
        st_q <= 2'd0;
      end else if (!armed_q) begin
        st_q   <= 2'd1;
        flag_q <= '0;
      end else if (step) begin
        st_q   <= cur_ctl[1:0];
        flag_q <= hit;
        fin_q  <= (cur_ctl[1:0] == 2'd0);
      end
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (sel) begin
      case (bank_sel)
        2'd0:    bus_rdata = {4'h0, ctl_q[0]};
        2'd1:    bus_rdata = {4'h0, ctl_q[1]};
        2'd2:    bus_rdata = {4'h0, ctl_q[2]};
        default: bus_rdata = {6'h00, flag_q};
      endcase
    end
  end

  assign seq_state   = st_q;
  assign final_pulse = fin_q;

endmodule

// File: rtl/dbg_seq_bank_chk.sv
module dbg_seq_bank_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       armed,
  input logic       final_pulse,
  input logic [1:0] seq_state,
  input logic [7:0] bus_rdata,
  input logic [3:0] c1,
  input logic [3:0] c2,
  input logic [3:0] c3
);

  AST_CTL_FROZEN_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> $stable({c1, c2, c3})); // R3

  AST_ARM_ENTERS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |=> (seq_state == 2'd1)); // R4

  AST_DISARM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> (seq_state == 2'd0) && !final_pulse); // R9

  AST_FINAL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    final_pulse |=> !final_pulse); // R7

  AST_FINAL_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    final_pulse |-> (seq_state == 2'd0)); // R7

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[7:4] == 4'h0); // R2

endmodule

bind dbg_seq_bank dbg_seq_bank_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .armed      (armed),
  .final_pulse(final_pulse),
  .seq_state  (seq_state),
  .bus_rdata  (bus_rdata),
  .c1         (ctl_q[0]),
  .c2         (ctl_q[1]),
  .c3         (ctl_q[2])
);

// File: tb/dbg_seq_bank_tb.sv
module dbg_seq_bank_tb;
  localparam int AW = 6;
  localparam logic [AW-1:0] SA = 6'h2A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [1:0] bank_sel = '0;
  logic armed = 1'b0;
  logic [1:0] hit = '0;
  logic [1:0] seq_state;
  logic final_pulse;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [3:0] m_ctl [3];
  logic [1:0] m_mf, m_st;
  logic m_fin, m_aq;

  always #5 clk = ~clk;

  dbg_seq_bank #(.AW(AW), .SEQ_ADDR(SA)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bank_sel(bank_sel),
    .armed(armed), .hit(hit), .seq_state(seq_state), .final_pulse(final_pulse)
  );

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_rd(logic [AW-1:0] a, logic [1:0] b);
    if (a != SA) return 8'h00;
    if (b == 2'd3) return {6'h00, m_mf};
    return {4'h0, m_ctl[b]};
  endfunction

  function automatic logic cond_met(logic [3:0] c, logic [1:0] h);
    case (c[3:2])
      2'b01:   return h[0];
      2'b10:   return h[1];
      2'b11:   return |h;
      default: return 1'b0;
    endcase
  endfunction

  task automatic model_step();
    logic [3:0] c;
    logic f;
    c = (m_st == 2'd0) ? 4'h0 : m_ctl[m_st - 2'd1];
    f = cond_met(c, hit);
    m_fin = 1'b0;
    if (bus_we && bus_addr == SA && bank_sel != 2'd3 && !armed)
      m_ctl[bank_sel] = bus_wdata[3:0];
    if (!armed) m_st = 2'd0;
    else if (!m_aq) begin m_st = 2'd1; m_mf = 2'd0; end
    else if (m_st != 2'd0 && f) begin
      m_mf = hit; m_fin = (c[1:0] == 2'd0); m_st = c[1:0];
    end
    m_aq = armed;
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check("R6 state", seq_state, m_st);
    check("R7 final", final_pulse, m_fin);
    check("R2 rdata", bus_rdata, exp_rd(bus_addr, bank_sel));
  endtask

  task automatic wr(logic [1:0] b, logic [7:0] d);
    bus_addr = SA; bank_sel = b; bus_wdata = d; bus_we = 1'b1;
    cyc();
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] b, logic [7:0] e, string tag);
    bus_addr = SA; bank_sel = b; #1;
    check(tag, bus_rdata, e);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_ctl[0] = 0; m_ctl[1] = 0; m_ctl[2] = 0;
    m_mf = 0; m_st = 0; m_fin = 0; m_aq = 0;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check("R1 state", seq_state, 0);
    check("R1 final", final_pulse, 0);
    for (int b = 0; b < 4; b++) rd(b[1:0], 8'h00, "R1 regs");
    rst_n = 1'b1;
    @(negedge clk);

    wr(2'd0, 8'hF6);
    wr(2'd1, 8'h8B);
    wr(2'd2, 8'h3C);
    rd(2'd0, 8'h06, "R3 write bank0");
    rd(2'd1, 8'h0B, "R3 write bank1");
    rd(2'd2, 8'h0C, "R2 bank2 hi bits zero");
    bus_addr = SA + 1; bank_sel = 2'd0; bus_wdata = 8'h01; bus_we = 1'b1; cyc(); bus_we = 1'b0;
    rd(2'd0, 8'h06, "R3 other address ignored");
    wr(2'd3, 8'hFF);
    rd(2'd3, 8'h00, "R3 flag bank write ignored");

    armed = 1'b1; cyc();
    check("R4 arm to state1", seq_state, 1);
    wr(2'd0, 8'h00);
    rd(2'd0, 8'h06, "R3 armed write blocked");
    hit = 2'b10; cyc();
    check("R5 wrong channel holds", seq_state, 1);
    hit = 2'b01; cyc();
    check("R5 ch0 to state2", seq_state, 2);
    hit = 2'b11; cyc();
    check("R5 ch1 to state3", seq_state, 3);
    rd(2'd3, 8'h03, "R8 flags captured");
    hit = 2'b10; cyc();
    check("R7 final pulse", final_pulse, 1);
    check("R7 idle at final", seq_state, 0);
    rd(2'd3, 8'h02, "R8 flags on final");
    hit = 2'b11; cyc();
    check("R7 pulse one cycle", final_pulse, 0);
    check("R7 stays idle", seq_state, 0);
    armed = 1'b0; cyc();
    armed = 1'b1; hit = 2'b00; cyc();
    rd(2'd3, 8'h00, "R4 flags cleared on arm");
    hit = 2'b01; cyc();
    check("R6 to state2 again", seq_state, 2);
    armed = 1'b0; hit = 2'b00; cyc();
    check("R9 disarm idle", seq_state, 0);
    check("R9 no pulse", final_pulse, 0);
    wr(2'd0, 8'h03);
    armed = 1'b1; cyc();
    hit = 2'b11; cyc();
    check("R5 cond 00 never fires", seq_state, 1);

    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 12 == 0) armed = ~armed;
      bus_we = ($urandom % 3 == 0);
      bus_addr = ($urandom % 4 == 0) ? AW'($urandom) : SA;
      bank_sel = 2'($urandom);
      bus_wdata = 8'($urandom);
      hit = ($urandom % 3 == 0) ? 2'($urandom) : 2'b00;
      cyc();
    end
    bus_we = 1'b0;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule